// File: doc/BRIEF.md
# Modem Handshake Flow Gate

This block sits between a frame transmitter/receiver pair and the three active-low modem handshake lines: request-to-send (output), clear-to-send and data-set-ready (inputs). A transmitter raises `tx_req` when a frame is queued. The gate answers with a one-cycle `tx_start` grant and treats the frame as in progress until the transmitter reports `tx_done`. When clear-to-send gating is on, a frame is granted only while the synchronised CTS line is low. The line is looked at only between frames, so a frame that has started always runs to its end. With automatic RTS on, the gate drives RTS low for exactly the span of each frame. Otherwise RTS follows a software bit. The receiver enable is either always on or follows the synchronised DSR line.

Both modem inputs pass through a two-flop synchroniser, and both reset to the inactive (high) level. The transmit side is a four-state machine:

- ST_IDLE: no request pending.
- ST_HOLD: a request is pending but CTS is blocking it.
- ST_GRANT: the one-cycle grant.
- ST_SEND: the frame is running.

Its transitions are:

- IDLE→GRANT when a request arrives and CTS permits it.
- IDLE→HOLD when a request arrives and CTS blocks it.
- HOLD→GRANT when CTS permits while the request is still present.
- HOLD→IDLE when the request is withdrawn (this check takes priority).
- GRANT→SEND always.
- SEND→IDLE on `tx_done`.

Returning to IDLE after every frame forces a fresh CTS evaluation before the next grant.

Top module: `modem_flow_gate`

## Requirements
- R1: After reset `tx_start`=0, `tx_active`=0, `rts_n` equals the inverse of `sw_rts`, and `rx_en`=1 while `cfg_dsr_auto`=0.
- R2: With `cfg_cts_auto`=0, a request is granted regardless of `cts_n`: `tx_start` is high for exactly one cycle, in the cycle after `tx_req` is first sampled high, and `tx_active` stays high from then on.
- R3: With `cfg_cts_auto`=1 and the synchronised CTS high, no grant is issued. Once it is low, a pending request is granted.
- R4: Once a frame has been granted, `tx_active` stays high and no further grant is issued until `tx_done` is sampled high, whatever `cts_n` does. `tx_active` falls in the cycle after `tx_done`.
- R5: After a frame completes, a request that is still pending is granted only after CTS is evaluated again (held while `cts_n`=1 with `cfg_cts_auto`=1).
- R6: With `cfg_rts_auto`=1, `rts_n` is 0 exactly while `tx_active`=1 and 1 otherwise.
- R7: With `cfg_rts_auto`=0, `rts_n` = NOT `sw_rts`, independent of frame activity.
- R8: With `cfg_dsr_auto`=0, `rx_en`=1 regardless of `dsr_n`.
- R9: With `cfg_dsr_auto`=1, `rx_en` equals the inverse of `dsr_n` delayed by two clock edges (receiver off while DSR high).
- R10: Each modem input is delayed by exactly two flops. A CTS fall that unblocks a held request produces `tx_start` after the third rising edge. A DSR change reaches `rx_en` after the second rising edge.
- R11: A request withdrawn while held returns the machine to idle, so a later CTS fall causes no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rts_auto | input | 1 | 1: RTS driven by frame activity |
| cfg_cts_auto | input | 1 | 1: grants gated by CTS |
| cfg_dsr_auto | input | 1 | 1: receiver gated by DSR |
| sw_rts | input | 1 | Software RTS request (1 = assert) used when automatic RTS is off |
| cts_n | input | 1 | Clear-to-send modem line, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready modem line, active low, asynchronous |
| tx_req | input | 1 | Transmitter has a frame ready |
| tx_done | input | 1 | Transmitter finished the current frame |
| tx_start | output | 1 | One-cycle grant to start a frame |
| tx_active | output | 1 | A granted frame is in progress |
| rts_n | output | 1 | Request-to-send modem line, active low |
| rx_en | output | 1 | Receiver enable |

## Verification
Frames are requested under four conditions:

- CTS gating off with CTS high, showing the gate is transparent.
- CTS gating on with CTS held high, then dropped. Counting edges to the grant confirms the two-flop delay.
- CTS raised in the middle of a frame with a second request already queued. This separates the boundary-only CTS check from a level-sensitive one, and checks that completion forces a new evaluation.
- A request withdrawn while held, showing that a later CTS fall leaves the machine idle.

RTS is observed in both automatic and software modes across whole frames. DSR is toggled with gating on and off, and the edge counts are checked.

// File: rtl/mfg_pkg.sv
package mfg_pkg;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_GRANT = 2'd2,
        ST_SEND  = 2'd3
    } mfg_state_e;
endpackage

// File: rtl/mfg_sync.sv
module mfg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam logic [WIDTH-1:0] IDLE_LVL = {WIDTH{1'b1}};

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= IDLE_LVL;
            end else if (s == 0) begin
                stage_q[s] <= async_in;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mfg_tx_fsm.sv
module mfg_tx_fsm
    import mfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_cts_auto,
    input  logic cfg_rts_auto,
    input  logic sw_rts,
    input  logic cts_s,
    input  logic tx_req,
    input  logic tx_done,
    output logic tx_start,
    output logic tx_active,
    output logic rts_n
);
    mfg_state_e state_q, state_d;
    logic       cts_ok;

    assign cts_ok = !cfg_cts_auto || !cts_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tx_req) state_d = cts_ok ? ST_GRANT : ST_HOLD;
            end
            ST_HOLD: begin
                if (!tx_req)     state_d = ST_IDLE;
                else if (cts_ok) state_d = ST_GRANT;
            end
            ST_GRANT: state_d = ST_SEND;
            ST_SEND: begin
                if (tx_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        tx_start  = (state_q == ST_GRANT);
        tx_active = (state_q == ST_GRANT) || (state_q == ST_SEND);
        rts_n     = cfg_rts_auto ? !tx_active : !sw_rts;
    end

    // R3: a grant implies CTS permitted it on the previous edge
    p_grant_cts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(!cfg_cts_auto || !cts_s));

    // R2: grant lasts one cycle and the frame is then in progress
    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> (!tx_start && tx_active));

    // R4: a frame ends only on a reported completion
    p_end_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_active) |-> $past(tx_done));
endmodule

// File: rtl/mfg_rx_gate.sv
module mfg_rx_gate (
    input  logic cfg_dsr_auto,
    input  logic dsr_s,
    output logic rx_en
);
    always_comb begin
        rx_en = !cfg_dsr_auto || !dsr_s;
    end
endmodule

// File: rtl/modem_flow_gate.sv
module modem_flow_gate
    import mfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_rts_auto,
    input  logic cfg_cts_auto,
    input  logic cfg_dsr_auto,
    input  logic sw_rts,
    input  logic cts_n,
    input  logic dsr_n,
    input  logic tx_req,
    input  logic tx_done,
    output logic tx_start,
    output logic tx_active,
    output logic rts_n,
    output logic rx_en
);
    localparam int LINES = 2;

    logic [LINES-1:0] pins_raw;
    logic [LINES-1:0] pins_s;

    assign pins_raw = {dsr_n, cts_n};

    mfg_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    mfg_tx_fsm u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_cts_auto (cfg_cts_auto),
        .cfg_rts_auto (cfg_rts_auto),
        .sw_rts       (sw_rts),
        .cts_s        (pins_s[0]),
        .tx_req       (tx_req),
        .tx_done      (tx_done),
        .tx_start     (tx_start),
        .tx_active    (tx_active),
        .rts_n        (rts_n)
    );

    mfg_rx_gate u_rx (
        .cfg_dsr_auto (cfg_dsr_auto),
        .dsr_s        (pins_s[1]),
        .rx_en        (rx_en)
    );

    // R9: DSR high two edges ago keeps the receiver off when gated
    p_rx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dsr_auto && $past(dsr_n, 2)) |-> !rx_en);

    // R8: ungated receiver is always enabled
    p_rx_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dsr_auto |-> rx_en);
endmodule

// File: tb/sim_modem_flow_gate.sv
`timescale 1ns/1ps
module sim_modem_flow_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rts_auto = 1'b0, cfg_cts_auto = 1'b0, cfg_dsr_auto = 1'b0;
    logic sw_rts = 1'b0, cts_n = 1'b1, dsr_n = 1'b1;
    logic tx_req = 1'b0, tx_done = 1'b0;
    logic tx_start, tx_active, rts_n, rx_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // expected RTS level at each grant; empty queue means no grant is allowed
    logic exp_q [$];

    always #2.5 clk = ~clk;

    modem_flow_gate u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_rts_auto(cfg_rts_auto), .cfg_cts_auto(cfg_cts_auto),
        .cfg_dsr_auto(cfg_dsr_auto), .sw_rts(sw_rts),
        .cts_n(cts_n), .dsr_n(dsr_n),
        .tx_req(tx_req), .tx_done(tx_done),
        .tx_start(tx_start), .tx_active(tx_active),
        .rts_n(rts_n), .rx_en(rx_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // monitor: every grant must be expected, and RTS must match then
    always @(negedge clk) begin
        if (rst_n && tx_start) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected grant", 1, 0);
            end else begin
                logic e;
                e = exp_q.pop_front();
                chk(rts_n == e, "R6", "rts_n at grant", rts_n, e);
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // wait for a grant already pushed to the scoreboard
    task automatic await_grant(input int limit, input string req);
        bit got = 1'b0;
        for (int i = 0; i < limit && !got; i++) begin
            @(negedge clk);
            if (tx_start) got = 1'b1;
        end
        chk(got, req, "grant seen", got, 1);
        tx_req = 1'b0;
    endtask

    // run a granted frame for len cycles, then report completion
    task automatic run_frame(input int len, input logic exp_rts, input string req);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            chk(tx_active == 1'b1, "R4", "tx_active mid-frame", tx_active, 1);
            chk(rts_n == exp_rts, req, "rts_n mid-frame", rts_n, exp_rts);
        end
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        chk(tx_active == 1'b0, "R4", "tx_active after done", tx_active, 0);
    endtask

    initial begin
        cycles(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_start == 1'b0, "R1", "tx_start reset", tx_start, 0);
        chk(tx_active == 1'b0, "R1", "tx_active reset", tx_active, 0);
        chk(rts_n == 1'b1, "R1", "rts_n reset", rts_n, 1);
        chk(rx_en == 1'b1, "R1", "rx_en reset", rx_en, 1);

        // R2: CTS gating off, CTS high
        cfg_rts_auto = 1'b1;
        cycles(3);
        exp_q.push_back(1'b0);
        tx_req = 1'b1;
        @(negedge clk);
        chk(tx_start == 1'b1, "R2", "grant one cycle after request", tx_start, 1);
        tx_req = 1'b0;
        @(negedge clk);
        chk(tx_start == 1'b0, "R2", "grant width", tx_start, 0);
        run_frame(4, 1'b0, "R6");
        chk(rts_n == 1'b1, "R6", "rts_n released after frame", rts_n, 1);

        // R3: CTS gating on, CTS high holds the request
        cfg_cts_auto = 1'b1;
        tx_req = 1'b1;
        cycles(20);
        chk(tx_active == 1'b0, "R3", "held while CTS high", tx_active, 0);
        // R10: CTS fall reaches the grant after the third edge
        exp_q.push_back(1'b0);
        cts_n = 1'b0;
        @(negedge clk);
        chk(tx_start == 1'b0, "R10", "no grant after edge 1", tx_start, 0);
        @(negedge clk);
        chk(tx_start == 1'b0, "R10", "no grant after edge 2", tx_start, 0);
        @(negedge clk);
        chk(tx_start == 1'b1, "R10", "grant after edge 3", tx_start, 1);
        tx_req = 1'b0;
        // R4: CTS rises mid-frame; next frame already queued
        cts_n = 1'b1;
        tx_req = 1'b1;
        run_frame(6, 1'b0, "R6");
        // R5: completion forces a fresh CTS evaluation
        cycles(15);
        chk(tx_active == 1'b0, "R5", "next frame held after completion", tx_active, 0);
        exp_q.push_back(1'b0);
        cts_n = 1'b0;
        await_grant(6, "R5");
        run_frame(3, 1'b0, "R6");

        // R11: withdrawn request while held
        cts_n = 1'b1;
        cycles(4);
        tx_req = 1'b1;
        cycles(10);
        tx_req = 1'b0;
        @(negedge clk);
        cts_n = 1'b0;
        cycles(10);
        chk(tx_active == 1'b0, "R11", "no grant after withdrawal", tx_active, 0);

        // R7: software RTS
        cfg_rts_auto = 1'b0;
        sw_rts = 1'b1;
        @(negedge clk);
        chk(rts_n == 1'b0, "R7", "rts_n follows sw_rts=1", rts_n, 0);
        sw_rts = 1'b0;
        @(negedge clk);
        chk(rts_n == 1'b1, "R7", "rts_n follows sw_rts=0", rts_n, 1);
        exp_q.push_back(1'b1);
        tx_req = 1'b1;
        await_grant(6, "R7");
        run_frame(3, 1'b1, "R7");

        // R8: DSR ungated
        dsr_n = 1'b0;
        cycles(3);
        chk(rx_en == 1'b1, "R8", "rx_en with dsr low", rx_en, 1);
        dsr_n = 1'b1;
        cycles(3);
        chk(rx_en == 1'b1, "R8", "rx_en with dsr high", rx_en, 1);

        // R9: DSR gated
        cfg_dsr_auto = 1'b1;
        @(negedge clk);
        chk(rx_en == 1'b0, "R9", "rx off while dsr high", rx_en, 0);
        dsr_n = 1'b0;
        @(negedge clk);
        chk(rx_en == 1'b0, "R10", "dsr fall not yet after edge 1", rx_en, 0);
        @(negedge clk);
        chk(rx_en == 1'b1, "R9", "rx on after edge 2", rx_en, 1);
        dsr_n = 1'b1;
        @(negedge clk);
        chk(rx_en == 1'b1, "R10", "dsr rise not yet after edge 1", rx_en, 1);
        @(negedge clk);
        chk(rx_en == 1'b0, "R9", "rx off after edge 2", rx_en, 0);

        cycles(3);
        chk(exp_q.size() == 0, "R2", "all expected grants seen", exp_q.size(), 0);
        summary();
    end

    initial begin
        #(5.0 * 100000);
        failures++;
        $display("FAIL R1 watchdog expired actual=1 expected=0");
        summary();
    end
endmodule